// File: doc/BRIEF.md
# Channel-Stealing Sub-Channel Allocator

This block decides, every cycle, which virtual channels (VCs) may place flits on the wide output channels of a router. Each output channel is split into as many flit-wide sub-channels as an input port has VCs. Every VC has a home sub-channel, the one with the same VC number, at the output its packet is routed to. A home sub-channel that its VCs leave unused is not wasted. It is handed to another VC heading to the same output, whether that VC sits on the same input port or on a different one. A VC can therefore move several flits in one cycle.

Each VC presents its output direction, the number of flits in its buffer and the credits its downstream buffer has left. The block is purely combinational from these inputs to its grants. Its only state is one round-robin pointer per output. For every sub-channel of every output it reports whether that sub-channel is used and which input VC won it. For every VC it reports how many flits it may send this cycle. The crossbar and buffer read logic use these results. They are outside this block.

Top module: `scs_steal_alloc`

## Requirements
- R1: A VC numbered s with a usable flit (usable = minimum of flits and credits, taken at its own output) gets sub-channel s of its output. When VCs numbered s on several inputs compete, inputs are scanned starting at input floor(ptr/V) of that output's pointer and wrapping, and the first wins.
- R2: Sub-channels still free after the home pass are given one at a time, in ascending sub-channel order, to VCs of the same output that still have usable flits. These VCs may sit on any input port.
- R3: The count granted to a VC never exceeds its buffered flits or its downstream credits.
- R4: grant_idx of sub-channel s at output o holds the flat VC index port*V+vc of the winner and is meaningful only when grant_vld[o*V+s] is 1. Every winner is routed to o.
- R5: At each output, the number of valid sub-channels equals the smaller of V and the total usable flits routed there.
- R6: Each spare pick scans flat VC indices upward from a cursor that starts at the output's pointer and wraps. After each pick the cursor moves to the winner plus one. At the clock edge the pointer takes the final cursor value if any spare was given, and keeps its value otherwise.
- R7: Synchronous active-high reset sets every output pointer to 0. With all VCs idle, no grant is valid and all counts are 0.
- R8: A VC with zero credits receives nothing, whatever its flit count. A direction code of P or above matches no output and requests nothing.
- R9: The home pass completes before any spare is given, so a VC with a usable flit is never displaced from its own sub-channel by a stealing VC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| vc_dir | input | P*V*DIR_W | Output direction of each VC, flat index port*V+vc |
| vc_flits | input | P*V*CNT_W | Buffered flits per VC |
| vc_cred | input | P*V*CNT_W | Downstream credits per VC |
| grant_vld | output | P*V | Sub-channel used, index output*V+sub |
| grant_idx | output | P*V*IDX_W | Winning flat VC index per sub-channel |
| vc_gnt_cnt | output | P*V*CNT_W | Flits granted to each VC this cycle |

## Verification
The bench builds the block with three ports, four VCs and 3-bit counts. Because three is not a power of two, both the input scan and the flat-index scan have to wrap at a boundary that is not a power of two. The unused direction code 3 serves as an idle VC. The 3-bit counts allow flit and credit values that differ, so the credit limit, the one-and-three split, the pointer walking across three contenders and pointer-driven rotation between inputs on a home sub-channel can all be reached.

// File: rtl/scs_pkg.sv
package scs_pkg;
    localparam int DEF_PORTS = 3;
    localparam int DEF_VCS   = 4;
    localparam int DEF_CNT_W = 3;

    // a and b both below m: modular add without a divider
    function automatic int wrap_add(input int a, input int b, input int m);
        int t;
        t = a + b;
        if (t >= m) t = t - m;
        return t;
    endfunction
endpackage

// File: rtl/scs_out_alloc.sv
module scs_out_alloc
    import scs_pkg::*;
#(
    parameter int P      = DEF_PORTS,
    parameter int V      = DEF_VCS,
    parameter int CNT_W  = DEF_CNT_W,
    parameter int DIR_W  = 2,
    parameter int IDX_W  = 4,
    parameter int OUT_ID = 0
) (
    input  logic [P*V*DIR_W-1:0] vc_dir,
    input  logic [P*V*CNT_W-1:0] vc_flits,
    input  logic [P*V*CNT_W-1:0] vc_cred,
    input  logic [IDX_W-1:0]     ptr_q,
    output logic [V-1:0]         sub_vld,
    output logic [V*IDX_W-1:0]   sub_idx,
    output logic [P*V*CNT_W-1:0] vc_cnt,
    output logic [IDX_W-1:0]     ptr_d
);
    localparam int N = P * V;

    logic [CNT_W-1:0] avail [N];
    logic [CNT_W-1:0] rem   [N];
    logic [CNT_W-1:0] fl, cr;
    logic             stole;
    int               cur, nxt, start_in, j;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            fl = vc_flits[i*CNT_W +: CNT_W];
            cr = vc_cred[i*CNT_W +: CNT_W];
            if (int'(vc_dir[i*DIR_W +: DIR_W]) == OUT_ID)
                avail[i] = (fl < cr) ? fl : cr;
            else
                avail[i] = '0;
            rem[i] = avail[i];
        end
        sub_vld  = '0;
        sub_idx  = '0;
        stole    = 1'b0;
        j        = 0;
        // home pass: sub-channel s is offered to VC s of each input
        start_in = int'(ptr_q) / V;
        for (int s = 0; s < V; s++) begin
            for (int k = 0; k < P; k++) begin
                j = wrap_add(start_in, k, P) * V + s;
                if (!sub_vld[s] && rem[j] != '0) begin
                    sub_vld[s]                 = 1'b1;
                    sub_idx[s*IDX_W +: IDX_W]  = IDX_W'(j);
                    rem[j]                     = rem[j] - CNT_W'(1);
                end
            end
        end
        // stealing pass: leftover sub-channels, rotating over all VCs
        cur = int'(ptr_q);
        for (int s = 0; s < V; s++) begin
            nxt = cur;
            if (!sub_vld[s]) begin
                for (int k = 0; k < N; k++) begin
                    j = wrap_add(cur, k, N);
                    if (!sub_vld[s] && rem[j] != '0) begin
                        sub_vld[s]                = 1'b1;
                        sub_idx[s*IDX_W +: IDX_W] = IDX_W'(j);
                        rem[j]                    = rem[j] - CNT_W'(1);
                        stole                     = 1'b1;
                        nxt                       = wrap_add(j, 1, N);
                    end
                end
            end
            cur = nxt;
        end
        ptr_d = stole ? IDX_W'(cur) : ptr_q;
        for (int i = 0; i < N; i++)
            vc_cnt[i*CNT_W +: CNT_W] = avail[i] - rem[i];
    end
endmodule

// File: rtl/scs_rr_reg.sv
module scs_rr_reg #(
    parameter int IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [IDX_W-1:0] d,
    output logic [IDX_W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end
endmodule

// File: rtl/scs_steal_alloc.sv
module scs_steal_alloc
    import scs_pkg::*;
#(
    parameter int P     = DEF_PORTS,
    parameter int V     = DEF_VCS,
    parameter int CNT_W = DEF_CNT_W,
    localparam int N     = P * V,
    localparam int DIR_W = (P > 1) ? $clog2(P + 1) : 1,
    localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N*DIR_W-1:0]   vc_dir,
    input  logic [N*CNT_W-1:0]   vc_flits,
    input  logic [N*CNT_W-1:0]   vc_cred,
    output logic [N-1:0]         grant_vld,
    output logic [N*IDX_W-1:0]   grant_idx,
    output logic [N*CNT_W-1:0]   vc_gnt_cnt
);
    logic [N*CNT_W-1:0] cnt_per_out [P];

    for (genvar o = 0; o < P; o++) begin : g_out
        logic [IDX_W-1:0] ptr_q, ptr_d;

        scs_out_alloc #(
            .P(P), .V(V), .CNT_W(CNT_W), .DIR_W(DIR_W),
            .IDX_W(IDX_W), .OUT_ID(o)
        ) alloc_i (
            .vc_dir  (vc_dir),
            .vc_flits(vc_flits),
            .vc_cred (vc_cred),
            .ptr_q   (ptr_q),
            .sub_vld (grant_vld[o*V +: V]),
            .sub_idx (grant_idx[o*V*IDX_W +: V*IDX_W]),
            .vc_cnt  (cnt_per_out[o]),
            .ptr_d   (ptr_d)
        );

        scs_rr_reg #(.IDX_W(IDX_W)) ptr_i (
            .clk(clk), .rst(rst), .d(ptr_d), .q(ptr_q)
        );
    end

    // a VC is routed to one output, so at most one term is nonzero
    always_comb begin
        vc_gnt_cnt = '0;
        for (int o = 0; o < P; o++)
            vc_gnt_cnt = vc_gnt_cnt | cnt_per_out[o];
    end
endmodule

// File: rtl/scs_steal_alloc_chk.sv
module scs_steal_alloc_chk #(
    parameter int P     = 3,
    parameter int V     = 4,
    parameter int CNT_W = 3,
    parameter int DIR_W = 2,
    parameter int IDX_W = 4
) (
    input logic                   clk,
    input logic                   rst,
    input logic [P*V*DIR_W-1:0]   vc_dir,
    input logic [P*V*CNT_W-1:0]   vc_flits,
    input logic [P*V*CNT_W-1:0]   vc_cred,
    input logic [P*V-1:0]         grant_vld,
    input logic [P*V*IDX_W-1:0]   grant_idx,
    input logic [P*V*CNT_W-1:0]   vc_gnt_cnt
);
    localparam int N = P * V;

    int       usable_sum [P];
    int       vld_sum    [P];
    int       cnt_sum    [P];
    logic     owner_ok   [N];
    int       w, d, f, c;

    always_comb begin
        for (int o = 0; o < P; o++) begin
            usable_sum[o] = 0;
            cnt_sum[o]    = 0;
            vld_sum[o]    = 0;
            for (int s = 0; s < V; s++)
                vld_sum[o] = vld_sum[o] + int'(grant_vld[o*V+s]);
        end
        for (int i = 0; i < N; i++) begin
            d = int'(vc_dir[i*DIR_W +: DIR_W]);
            f = int'(vc_flits[i*CNT_W +: CNT_W]);
            c = int'(vc_cred[i*CNT_W +: CNT_W]);
            if (d < P) begin
                usable_sum[d] = usable_sum[d] + ((f < c) ? f : c);
                cnt_sum[d]    = cnt_sum[d] + int'(vc_gnt_cnt[i*CNT_W +: CNT_W]);
            end
        end
        for (int g = 0; g < N; g++) begin
            w = int'(grant_idx[g*IDX_W +: IDX_W]);
            if (!grant_vld[g]) owner_ok[g] = 1'b1;
            else if (w >= N)   owner_ok[g] = 1'b0;
            else owner_ok[g] = (int'(vc_dir[w*DIR_W +: DIR_W]) == g / V) &&
                               (vc_gnt_cnt[w*CNT_W +: CNT_W] != '0);
        end
    end

    for (genvar i = 0; i < N; i++) begin : g_vc
        a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
            (vc_gnt_cnt[i*CNT_W +: CNT_W] <= vc_flits[i*CNT_W +: CNT_W]) &&
            (vc_gnt_cnt[i*CNT_W +: CNT_W] <= vc_cred[i*CNT_W +: CNT_W]));
        a_r8_no_credit_no_grant: assert property (@(posedge clk) disable iff (rst)
            (vc_cred[i*CNT_W +: CNT_W] == '0) |-> (vc_gnt_cnt[i*CNT_W +: CNT_W] == '0));
        a_r4_winner_routed_here: assert property (@(posedge clk) disable iff (rst)
            owner_ok[i]);
    end

    for (genvar o = 0; o < P; o++) begin : g_o
        a_r5_work_conserving: assert property (@(posedge clk) disable iff (rst)
            vld_sum[o] == ((usable_sum[o] < V) ? usable_sum[o] : V));
        a_r2_counts_match_slots: assert property (@(posedge clk) disable iff (rst)
            cnt_sum[o] == vld_sum[o]);
    end
endmodule

bind scs_steal_alloc scs_steal_alloc_chk #(
    .P(P), .V(V), .CNT_W(CNT_W), .DIR_W(DIR_W), .IDX_W(IDX_W)
) chk_i (
    .clk(clk), .rst(rst), .vc_dir(vc_dir), .vc_flits(vc_flits),
    .vc_cred(vc_cred), .grant_vld(grant_vld), .grant_idx(grant_idx),
    .vc_gnt_cnt(vc_gnt_cnt)
);

// File: tb/scs_steal_alloc_tb_top.sv
module scs_steal_alloc_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int P = 3, V = 4, CNT_W = 3;
    localparam int N = P * V, DIR_W = 2, IDX_W = 4;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [N*DIR_W-1:0] vc_dir;
    logic [N*CNT_W-1:0] vc_flits, vc_cred;
    logic [N-1:0]       grant_vld;
    logic [N*IDX_W-1:0] grant_idx;
    logic [N*CNT_W-1:0] vc_gnt_cnt;

    int n_vec = 0, n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    scs_steal_alloc #(.P(P), .V(V), .CNT_W(CNT_W)) dut_i (
        .clk(clk), .rst(rst), .vc_dir(vc_dir), .vc_flits(vc_flits),
        .vc_cred(vc_cred), .grant_vld(grant_vld), .grant_idx(grant_idx),
        .vc_gnt_cnt(vc_gnt_cnt)
    );

    task automatic clear_vcs();
        for (int i = 0; i < N; i++) begin
            vc_dir[i*DIR_W +: DIR_W]   = 2'd3;  // idle code
            vc_flits[i*CNT_W +: CNT_W] = '0;
            vc_cred[i*CNT_W +: CNT_W]  = '0;
        end
    endtask

    task automatic set_vc(input int i, input int d, input int f, input int c);
        vc_dir[i*DIR_W +: DIR_W]   = DIR_W'(d);
        vc_flits[i*CNT_W +: CNT_W] = CNT_W'(f);
        vc_cred[i*CNT_W +: CNT_W]  = CNT_W'(c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        clear_vcs();
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic chk_sub(input int o, input int s, input bit ev, input int ei, input string tag);
        bit av;
        int ai;
        av = grant_vld[o*V+s];
        ai = int'(grant_idx[(o*V+s)*IDX_W +: IDX_W]);
        n_vec++;
        if (av != ev || (ev && ai != ei)) begin
            n_bad++;
            $display("FAIL %s out%0d sub%0d: vld=%0b idx=%0d expected vld=%0b idx=%0d",
                     tag, o, s, av, ai, ev, ei);
        end
    endtask

    task automatic chk_cnt(input int i, input int e, input string tag);
        int a;
        a = int'(vc_gnt_cnt[i*CNT_W +: CNT_W]);
        n_vec++;
        if (a != e) begin
            n_bad++;
            $display("FAIL %s vc%0d count=%0d expected %0d", tag, i, a, e);
        end
    endtask

    // R7: idle after reset
    task automatic t_reset();
        do_reset();
        #1;
        for (int o = 0; o < P; o++)
            for (int s = 0; s < V; s++) chk_sub(o, s, 1'b0, 0, "R7");
        for (int i = 0; i < N; i++) chk_cnt(i, 0, "R7");
    endtask

    // R1: home sub-channels
    task automatic t_home();
        do_reset();
        for (int i = 0; i < 4; i++) set_vc(i, 1, 1, 5);
        #1;
        for (int s = 0; s < V; s++) chk_sub(1, s, 1'b1, s, "R1");
        for (int i = 0; i < 4; i++) chk_cnt(i, 1, "R1");
        chk_sub(0, 0, 1'b0, 0, "R4");
    endtask

    // R6: one spare shared by three VCs, pointer walks
    task automatic t_rotate();
        do_reset();
        for (int i = 0; i < 3; i++) set_vc(i, 0, 2, 7);
        #1;
        for (int s = 0; s < 3; s++) chk_sub(0, s, 1'b1, s, "R6");
        chk_sub(0, 3, 1'b1, 0, "R6");
        chk_cnt(0, 2, "R6");
        chk_cnt(1, 1, "R6");
        @(negedge clk); #1;
        chk_sub(0, 3, 1'b1, 1, "R6");
        @(negedge clk); #1;
        chk_sub(0, 3, 1'b1, 2, "R6");
        @(negedge clk); #1;
        chk_sub(0, 3, 1'b1, 0, "R6");
    endtask

    // R2: one-and-three split inside one input
    task automatic t_split();
        do_reset();
        set_vc(0, 0, 1, 7);
        set_vc(1, 0, 3, 7);
        #1;
        chk_sub(0, 0, 1'b1, 0, "R2");
        for (int s = 1; s < V; s++) chk_sub(0, s, 1'b1, 1, "R2");
        chk_cnt(0, 1, "R2");
        chk_cnt(1, 3, "R2");
    endtask

    // R2/R5: stealing across inputs
    task automatic t_cross();
        do_reset();
        set_vc(0, 2, 4, 7);
        set_vc(9, 2, 1, 7);
        #1;
        chk_sub(2, 0, 1'b1, 0, "R2");
        chk_sub(2, 1, 1'b1, 9, "R2");
        chk_sub(2, 2, 1'b1, 0, "R5");
        chk_sub(2, 3, 1'b1, 0, "R5");
        chk_cnt(0, 3, "R2");
        chk_cnt(9, 1, "R2");
    endtask

    // R3/R8: credit limits
    task automatic t_credit();
        do_reset();
        set_vc(6, 0, 5, 2);
        set_vc(7, 0, 3, 0);
        #1;
        chk_sub(0, 0, 1'b1, 6, "R3");
        chk_sub(0, 1, 1'b0, 0, "R3");
        chk_sub(0, 2, 1'b1, 6, "R3");
        chk_sub(0, 3, 1'b0, 0, "R8");
        chk_cnt(6, 2, "R3");
        chk_cnt(7, 0, "R8");
    endtask

    // R1: contention on a home sub-channel rotates with the pointer
    task automatic t_contend();
        do_reset();
        set_vc(1, 1, 1, 1);
        set_vc(9, 1, 1, 1);
        #1;
        chk_sub(1, 1, 1'b1, 1, "R1");
        chk_sub(1, 0, 1'b1, 9, "R5");
        @(negedge clk); #1;
        chk_sub(1, 1, 1'b1, 9, "R1");
        chk_sub(1, 0, 1'b1, 1, "R6");
        chk_cnt(1, 1, "R5");
        chk_cnt(9, 1, "R5");
    endtask

    // R9: home slot kept against a greedy VC
    task automatic t_home_first();
        do_reset();
        set_vc(0, 0, 1, 7);
        set_vc(5, 0, 7, 7);
        #1;
        chk_sub(0, 0, 1'b1, 0, "R9");
        chk_sub(0, 1, 1'b1, 5, "R9");
        chk_sub(0, 2, 1'b1, 5, "R9");
        chk_sub(0, 3, 1'b1, 5, "R9");
        chk_cnt(0, 1, "R9");
        chk_cnt(5, 3, "R9");
    endtask

    // R6: saturated output, nothing stolen, pointer holds
    task automatic t_full();
        do_reset();
        for (int i = 0; i < N; i++) set_vc(i, 0, 7, 7);
        #1;
        for (int s = 0; s < V; s++) chk_sub(0, s, 1'b1, s, "R6");
        chk_cnt(4, 0, "R6");
        @(negedge clk); #1;
        for (int s = 0; s < V; s++) chk_sub(0, s, 1'b1, s, "R6");
        chk_cnt(0, 1, "R4");
    endtask

    initial begin
        clear_vcs();
        t_reset();
        t_home();
        t_rotate();
        t_split();
        t_cross();
        t_credit();
        t_contend();
        t_home_first();
        t_full();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end
endmodule